// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM Front End

This block models the control path and storage of a static memory that has one read port and one write port, both moving two data words per clock cycle. Each clock cycle of the single system clock carries a "rise" word and a "fall" word, which stand for the two halves of a double-data-rate beat pair. Read and write commands are active low. They share one address bus and are sampled on the rising clock edge. Each accepted command moves exactly four words at four consecutive addresses inside an aligned group of four.

Two independent burst sequencers let a read burst and a write burst run in the same cycles. Write data arrives in the two cycles after the write command, with a per-byte active-low enable for every word. Read data leaves in the two cycles after the read command, marked by a valid strobe. A read that overlaps a write still in flight returns the freshly written bytes, taken straight from the write path. The storage is a behavioural register array split into an even bank and an odd bank. Its depth is set by a parameter, and the upper address bits alias onto it.

Top module: `quad_burst_sram`

## Requirements
- R1: While `rst` is high, and until the first read is accepted after reset, `rdat_vld` is low. A command held low during reset is not accepted.
- R2: A read is accepted when `rd_cmd_n` is low at a rising edge and no read was accepted at the previous edge. Its words 1 and 2 appear on `rdat_rise`/`rdat_fall` in the cycle after the next edge, and words 3 and 4 appear in the cycle after that, with `rdat_vld` high in both cycles.
- R3: A write is accepted when `wr_cmd_n` is low at a rising edge and no write was accepted at the previous edge. Words 1 and 2 are taken from `wdat_rise`/`wdat_fall` at the next edge, and words 3 and 4 at the edge after that.
- R4: Word k (k = 0..3) of a burst goes to address bits [AW-1:2] of the command address, with the two low bits equal to (command low bits + k) mod 4. The burst wraps inside its aligned group of four.
- R5: A request of the same type at the edge right after an accepted one is discarded. A request two edges later is accepted, so commands every second edge give a gap-free stream of words.
- R6: A read burst and a write burst proceed independently and may overlap in time.
- R7: The byte enables are active low. Bit 0 gates data bits [8:0] and bit 1 gates bits [17:9]. They are sampled with each word, and a word whose enables are all high writes nothing.
- R8: A read word fetched at an edge reflects every write word taken at that same edge or earlier, merged byte by byte. Words 1-2 are fetched at the first edge after the read command, and words 3-4 at the second.
- R9: `rdat_vld` goes low in the cycle after the last word of a burst when no further read was accepted.
- R10: Only the low MEM_AW address bits select a storage word. Addresses that differ only above bit MEM_AW-1 reach the same word.
- R11: Write data and enables presented in cycles that carry no write-burst word have no effect on the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_cmd_n | input | 1 | Read request, active low |
| wr_cmd_n | input | 1 | Write request, active low |
| cmd_addr | input | AW | Shared burst start address |
| wdat_rise | input | DW | First write word of the current pair |
| wdat_fall | input | DW | Second write word of the current pair |
| wben_rise | input | NB | Active-low byte enables for `wdat_rise` |
| wben_fall | input | NB | Active-low byte enables for `wdat_fall` |
| rdat_rise | output | DW | First read word of the current pair |
| rdat_fall | output | DW | Second read word of the current pair |
| rdat_vld | output | 1 | High while a read word pair is driven |

## Verification
The in-RTL properties watch, on every cycle, the two-cycle spacing between an accepted read and its valid strobe, the refusal of a same-type request at the very next edge, the wrap of the second word pair inside the aligned group, and the per-byte substitution of same-edge write data into the read result. What ends up stored can only be shown by the bench's scenarios, which compare against a queue-based model. These scenarios cover partial and empty byte masks, unaligned bursts, aliased high addresses, write data driven outside any burst, read/write overlaps at several offsets, and streams held low on consecutive edges.

// File: rtl/qb_pkg.sv
package qb_pkg;
  // Sequencer phase: FIRST means the next edge moves words 1-2,
  // SECOND means the next edge moves words 3-4.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } burst_ph_e;

  localparam int WORDS_PER_CMD = 4;
  localparam int WORDS_PER_CLK = 2;
endpackage

// File: rtl/qb_burst_seq.sv
module qb_burst_seq
  import qb_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_n,
  input  logic [AW-1:0] cmd_addr,
  output logic          accept,
  output logic          busy,
  output logic [AW-1:0] lane0_addr,
  output logic [AW-1:0] lane1_addr
);
  localparam int CNT_W = $clog2(WORDS_PER_CMD);

  burst_ph_e      ph;
  logic [AW-1:0]  base;
  logic [CNT_W-1:0] off0;
  logic [CNT_W-1:0] cnt0;
  logic [CNT_W-1:0] cnt1;

  // A request landing while words 1-2 are due is discarded.
  assign accept = !cmd_n && (ph != PH_FIRST);
  assign busy   = (ph != PH_IDLE);

  // Linear counter wrapping inside the aligned group of four.
  assign off0 = (ph == PH_SECOND) ? CNT_W'(WORDS_PER_CLK) : '0;
  assign cnt0 = base[CNT_W-1:0] + off0;
  assign cnt1 = cnt0 + CNT_W'(1);
  assign lane0_addr = {base[AW-1:CNT_W], cnt0};
  assign lane1_addr = {base[AW-1:CNT_W], cnt1};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      base <= '0;
    end else if (accept) begin
      ph   <= PH_FIRST;
      base <= cmd_addr;
    end else if (ph == PH_FIRST) begin
      ph   <= PH_SECOND;
    end else begin
      ph   <= PH_IDLE;
    end
  end

  AST_SEQ_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept); // R5

  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SECOND) |-> (lane0_addr[AW-1:CNT_W] == $past(lane0_addr[AW-1:CNT_W]) &&
                           lane0_addr[CNT_W-1:0] == $past(lane0_addr[CNT_W-1:0]) + CNT_W'(2))); // R4
endmodule

// File: rtl/qb_sram_bank.sv
module qb_sram_bank #(
  parameter int IW = 7,
  parameter int DW = 18,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wben_n,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] dout
);
  localparam int BYTE_W = DW / NB;
  localparam int DEPTH  = 1 << IW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [DW-1:0] fwd_q;
  logic [NB-1:0] fwd_sel_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (we && !wben_n[b])
        mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end

    // Registered read returns the old word; same-edge write bytes override.
    assign dout[b*BYTE_W +: BYTE_W] = fwd_sel_q[b] ? fwd_q[b*BYTE_W +: BYTE_W]
                                                   : rd_q[b*BYTE_W +: BYTE_W];

    AST_BANK_FWD: assert property (@(posedge clk) disable iff (rst)
      (we && (raddr == waddr) && !wben_n[b]) |=>
        (dout[b*BYTE_W +: BYTE_W] == $past(wdata[b*BYTE_W +: BYTE_W]))); // R8
  end

  always_ff @(posedge clk) begin
    rd_q  <= mem[raddr];
    fwd_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      fwd_sel_q <= '0;
    else if (we && (raddr == waddr))
      fwd_sel_q <= ~wben_n;
    else
      fwd_sel_q <= '0;
  end
endmodule

// File: rtl/quad_burst_sram.sv
module quad_burst_sram
  import qb_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 18,
  parameter int NB     = 2,
  parameter int MEM_AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_cmd_n,
  input  logic          wr_cmd_n,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wdat_rise,
  input  logic [DW-1:0] wdat_fall,
  input  logic [NB-1:0] wben_rise,
  input  logic [NB-1:0] wben_fall,
  output logic [DW-1:0] rdat_rise,
  output logic [DW-1:0] rdat_fall,
  output logic          rdat_vld
);
  localparam int IW    = MEM_AW - 1;
  localparam int NBANK = WORDS_PER_CLK;

  logic          r_acc, r_go, w_acc, w_go;
  logic [AW-1:0] ra_rise, ra_fall, wa_rise, wa_fall;

  qb_burst_seq #(.AW(AW)) i_rd_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_n      (rd_cmd_n),
    .cmd_addr   (cmd_addr),
    .accept     (r_acc),
    .busy       (r_go),
    .lane0_addr (ra_rise),
    .lane1_addr (ra_fall)
  );

  qb_burst_seq #(.AW(AW)) i_wr_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_n      (wr_cmd_n),
    .cmd_addr   (cmd_addr),
    .accept     (w_acc),
    .busy       (w_go),
    .lane0_addr (wa_rise),
    .lane1_addr (wa_fall)
  );

  // The two words of one edge always differ in address bit 0, so each
  // bank (even/odd) sees exactly one write and one read per edge.
  logic [IW-1:0] bk_waddr [NBANK];
  logic [IW-1:0] bk_raddr [NBANK];
  logic [DW-1:0] bk_wdata [NBANK];
  logic [NB-1:0] bk_wben  [NBANK];
  logic [DW-1:0] bk_dout  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic w_from_rise;
    logic r_from_rise;
    assign w_from_rise = (wa_rise[0] == 1'(b));
    assign r_from_rise = (ra_rise[0] == 1'(b));
    assign bk_waddr[b] = w_from_rise ? wa_rise[MEM_AW-1:1] : wa_fall[MEM_AW-1:1];
    assign bk_wdata[b] = w_from_rise ? wdat_rise : wdat_fall;
    assign bk_wben[b]  = w_from_rise ? wben_rise : wben_fall;
    assign bk_raddr[b] = r_from_rise ? ra_rise[MEM_AW-1:1] : ra_fall[MEM_AW-1:1];

    qb_sram_bank #(.IW(IW), .DW(DW), .NB(NB)) i_bank (
      .clk    (clk),
      .rst    (rst),
      .we     (w_go),
      .waddr  (bk_waddr[b]),
      .wdata  (bk_wdata[b]),
      .wben_n (bk_wben[b]),
      .raddr  (bk_raddr[b]),
      .dout   (bk_dout[b])
    );
  end

  logic rd_vld_q;
  logic rd_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q <= 1'b0;
      rd_sel_q <= 1'b0;
    end else begin
      rd_vld_q <= r_go;
      rd_sel_q <= ra_rise[0];
    end
  end

  assign rdat_vld  = rd_vld_q;
  assign rdat_rise = rd_sel_q ? bk_dout[1] : bk_dout[0];
  assign rdat_fall = rd_sel_q ? bk_dout[0] : bk_dout[1];

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    r_acc |=> ##1 rdat_vld); // R2

  AST_RD_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(rdat_vld) |=> rdat_vld); // R2

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !r_go |=> !rdat_vld); // R9

  AST_RD_LANE_GROUP: assert property (@(posedge clk) disable iff (rst)
    r_go |-> (ra_rise[AW-1:2] == ra_fall[AW-1:2])); // R4

  AST_WR_LANE_GROUP: assert property (@(posedge clk) disable iff (rst)
    w_go |-> (wa_rise[AW-1:2] == wa_fall[AW-1:2])); // R4

  AST_WR_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    w_acc |=> !w_acc); // R5
endmodule

// File: tb/test_quad_burst_sram.sv
module test_quad_burst_sram;
  localparam int AW  = 20;
  localparam int DW  = 18;
  localparam int NB  = 2;
  localparam int MAW = 8;
  localparam int MSZ = 1 << MAW;
  localparam int BW  = DW / NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd_rise = '0;
  logic [DW-1:0] wd_fall = '0;
  logic [NB-1:0] be_rise = '1;
  logic [NB-1:0] be_fall = '1;
  wire  [DW-1:0] q_rise;
  wire  [DW-1:0] q_fall;
  wire           q_vld;

  quad_burst_sram #(.AW(AW), .DW(DW), .NB(NB), .MEM_AW(MAW)) i_quad_burst_sram (
    .clk       (clk),
    .rst       (rst),
    .rd_cmd_n  (rd_n),
    .wr_cmd_n  (wr_n),
    .cmd_addr  (addr),
    .wdat_rise (wd_rise),
    .wdat_fall (wd_fall),
    .wben_rise (be_rise),
    .wben_fall (be_fall),
    .rdat_rise (q_rise),
    .rdat_fall (q_fall),
    .rdat_vld  (q_vld)
  );

  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  // ---------------- reference model (queues of word indices) -------------
  logic [DW-1:0] ref_mem [MSZ];
  int            rq[$];
  int            wq[$];
  bit            prev_r = 1'b0;
  bit            prev_w = 1'b0;
  bit            exp_vld = 1'b0;
  logic [DW-1:0] exp_rise = '0;
  logic [DW-1:0] exp_fall = '0;

  function automatic int word_idx(input logic [AW-1:0] a, input int k);
    int v;
    v = int'(a);
    return ((v & ~3) | ((v + k) & 3)) & (MSZ - 1);
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NB-1:0] be_n);
    logic [DW-1:0] r;
    r = old;
    for (int b = 0; b < NB; b++)
      if (!be_n[b]) r[b*BW +: BW] = nw[b*BW +: BW];
    return r;
  endfunction

  always @(posedge clk) begin : model
    int a0;
    int a1;
    if (rst) begin
      rq.delete();
      wq.delete();
      prev_r  = 1'b0;
      prev_w  = 1'b0;
      exp_vld = 1'b0;
    end else begin
      if (wq.size() >= 2) begin
        a0 = wq.pop_front();
        a1 = wq.pop_front();
        ref_mem[a0] = merge(ref_mem[a0], wd_rise, be_rise);
        ref_mem[a1] = merge(ref_mem[a1], wd_fall, be_fall);
      end
      if (rq.size() >= 2) begin
        a0 = rq.pop_front();
        a1 = rq.pop_front();
        exp_rise = ref_mem[a0];
        exp_fall = ref_mem[a1];
        exp_vld  = 1'b1;
      end else begin
        exp_vld = 1'b0;
      end
      if (!rd_n && !prev_r) begin
        for (int k = 0; k < 4; k++) rq.push_back(word_idx(addr, k));
        prev_r = 1'b1;
      end else prev_r = 1'b0;
      if (!wr_n && !prev_w) begin
        for (int k = 0; k < 4; k++) wq.push_back(word_idx(addr, k));
        prev_w = 1'b1;
      end else prev_w = 1'b0;
    end
  end

  bit done = 1'b0;

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        check(q_vld == 1'b0, "valid during reset", 32'(q_vld), 32'd0); // R1
      end else begin
        check(q_vld == exp_vld, "valid", 32'(q_vld), 32'(exp_vld));
        if (exp_vld && q_vld) begin
          check(q_rise == exp_rise, "rise word", 32'(q_rise), 32'(exp_rise));
          check(q_fall == exp_fall, "fall word", 32'(q_fall), 32'(exp_fall));
        end
      end
    end
  end

  // ---------------- stimulus driver --------------------------------------
  logic [DW-1:0] dq_data[$];
  logic [NB-1:0] dq_be[$];
  bit            drv_prev_w = 1'b0;

  // One cycle: command lines, then write words owed by earlier write commands
  // (or junk with enables active), then queue the words of a new write.
  task automatic cyc(input bit do_r, input bit do_w, input logic [AW-1:0] a,
                     input logic [DW-1:0] seed, input logic [4*NB-1:0] be_all);
    rd_n = !do_r;
    wr_n = !do_w;
    addr = a;
    if (dq_data.size() >= 2) begin
      wd_rise = dq_data.pop_front();
      be_rise = dq_be.pop_front();
      wd_fall = dq_data.pop_front();
      be_fall = dq_be.pop_front();
    end else begin
      wd_rise = DW'($urandom);
      wd_fall = DW'($urandom);
      be_rise = '0; // R11: junk with enables active
      be_fall = '0;
    end
    if (do_w && !drv_prev_w) begin
      for (int k = 0; k < 4; k++) begin
        dq_data.push_back(seed ^ DW'(k * 713 + 1));
        dq_be.push_back(be_all[k*NB +: NB]);
      end
      drv_prev_w = 1'b1;
    end else drv_prev_w = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, AW'($urandom), '0, '0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    // R1: commands held low throughout reset must not start bursts
    rst  = 1'b1;
    rd_n = 1'b0;
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    rst  = 1'b0;
    rd_n = 1'b1;
    wr_n = 1'b1;
    idle(3);

    // R3: fill every word with aligned back-to-back write bursts
    cur_req = "R3";
    for (int b = 0; b < MSZ; b += 4) begin
      cyc(1'b0, 1'b1, AW'(b), DW'(b * 5 + 3), '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
    end
    idle(2);

    // R2: back-to-back aligned reads
    cur_req = "R2";
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, 1'b0, AW'(i * 4), '0, '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
    end
    idle(3);

    // R9: lone read, then idle; valid must fall
    cur_req = "R9";
    cyc(1'b1, 1'b0, AW'(8), '0, '0);
    idle(4);

    // R4: unaligned bursts wrap inside their group of four
    cur_req = "R4";
    for (int o = 1; o < 4; o++) begin
      cyc(1'b0, 1'b1, AW'(64 + 8 * o + o), DW'(o * 91 + 17), '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
    end
    idle(2);
    for (int o = 1; o < 4; o++) begin
      cyc(1'b1, 1'b0, AW'(64 + 8 * o + o), '0, '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
      cyc(1'b1, 1'b0, AW'(64 + 8 * o + 3), '0, '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
    end
    idle(3);

    // R5: requests held low on consecutive edges
    cur_req = "R5";
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, AW'(i * 8 + 2), '0, '0);
    idle(3);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, AW'(128 + i * 4), DW'(i * 333 + 5), '0);
    idle(2);
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b0, AW'(128 + i * 4), '0, '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
    end
    idle(3);

    // R6: overlapping read and write bursts on different addresses
    cur_req = "R6";
    cyc(1'b1, 1'b0, AW'(20), '0, '0);
    cyc(1'b0, 1'b1, AW'(200), DW'(18'h2aaaa), '0);
    cyc(1'b1, 1'b0, AW'(24), '0, '0);
    cyc(1'b0, 1'b1, AW'(204), DW'(18'h15555), '0);
    idle(2);
    cyc(1'b1, 1'b0, AW'(200), '0, '0);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b1, 1'b0, AW'(204), '0, '0);
    idle(3);

    // R7: byte-enable patterns, including a word with nothing enabled
    cur_req = "R7";
    cyc(1'b0, 1'b1, AW'(36), DW'(18'h3ffff), 8'b11_00_10_01);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b0, 1'b1, AW'(40), DW'(18'h00f0f), 8'b01_10_11_11);
    idle(2);
    cyc(1'b1, 1'b0, AW'(36), '0, '0);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b1, 1'b0, AW'(40), '0, '0);
    idle(3);

    // R8: reads overlapping in-flight writes at several offsets
    cur_req = "R8";
    cyc(1'b1, 1'b1, AW'(48), DW'(18'h1c3c3), 8'b00_10_01_00);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b0, 1'b1, AW'(52), DW'(18'h0a5a5), 8'b01_00_00_10);
    cyc(1'b1, 1'b0, AW'(52), '0, '0);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b1, 1'b0, AW'(56), '0, '0);
    cyc(1'b0, 1'b1, AW'(56), DW'(18'h31313), '0);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b0, 1'b1, AW'(61), DW'(18'h27272), 8'b10_00_01_00);
    cyc(1'b1, 1'b0, AW'(62), '0, '0);
    idle(3);
    cyc(1'b1, 1'b0, AW'(56), '0, '0);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b1, 1'b0, AW'(60), '0, '0);
    idle(3);

    // R10: high address bits alias onto the same word
    cur_req = "R10";
    cyc(1'b0, 1'b1, AW'(20'h53a11), DW'(18'h12345), '0);
    cyc(1'b0, 1'b0, '0, '0, '0);
    idle(1);
    cyc(1'b1, 1'b0, AW'(20'h00010), '0, '0);
    cyc(1'b0, 1'b0, '0, '0, '0);
    cyc(1'b1, 1'b0, AW'(20'hfff13), '0, '0);
    idle(3);

    // R11: idle cycles carried junk data with enables active; nothing changed
    cur_req = "R11";
    idle(6);
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, AW'(i * 4), '0, '0);
      cyc(1'b0, 1'b0, '0, '0, '0);
    end
    idle(4);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule